// File: doc/BRIEF.md
# JTAG Variable-Length Shift Sequencer

This block drives a JTAG test access port as the master. It moves a vector of 1 to 255 bits through whichever TAP register is selected, either the instruction register or the data register. It produces TCK, TMS and TDI and samples TDO. A transfer is started with a single-cycle request. The request carries the bit count, a 256-bit buffer and three options:

- the shift order, either lowest position first or highest position first;
- a flag that keeps the TAP in the shift state after the last bit;
- a flag that stops the sequence in the update state instead of returning to Run-Test/Idle.

The TDO value captured for each bit is written back into the buffer position that bit was taken from.

The block keeps its own record of the TAP controller state and exposes it as an output. Another agent can overwrite that record through a load port, for example after it has walked the TAP into Shift-IR or Shift-DR. A transfer is accepted only when the recorded state is one of the two shift states. TCK runs at the system clock divided by an even parameter and stays low between transfers.

Top module: `jtag_shift_seq`

## Requirements
- R1: A request made while the recorded state is not Shift-DR (code 4) or Shift-IR (code 11), or with a bit count of 0, is refused. `err` pulses for one cycle on the cycle after the request, `busy` stays low and no TCK edge occurs.
- R2: During a transfer, each TCK pulse is TCK_DIV/2 system cycles low followed by TCK_DIV/2 cycles high. The first rising edge comes TCK_DIV/2 cycles after acceptance. TCK is low whenever `busy` is low.
- R3: With `msb_first` low, data step k (k = 0 .. N-1) drives TDI from `data_in[k]`.
- R4: With `msb_first` high, data step k drives TDI from `data_in[N-1-k]`. This is the highest used position first, working down to position 0.
- R5: When the transfer ends, `data_out` holds the TDO value sampled at each data step, placed in the position that step took its TDI bit from. Every position at or above N reads 0.
- R6: With `no_end` low, TMS is low for data steps 0 .. N-2 and high for step N-1, so the recorded state becomes the matching Exit1 state.
- R7: With `no_end` low, one more pulse follows with TMS high and TDI low, ending in Update-DR (8) or Update-IR (15). Unless `no_idle` is high, a final pulse follows with TMS low and TDI low, ending in Run-Test/Idle (1). When `no_end` is high, `no_idle` has no effect.
- R8: With `no_end` high, TMS is low on all N pulses, no extra pulses follow, and the recorded state is unchanged at the end.
- R9: TDI and TMS change only while TCK is low. TDO is sampled on the system clock edge that drives TCK low.
- R10: `busy` is high for exactly TCK_DIV x P cycles, where P is the total pulse count. It falls on the edge that drives the last TCK low. `done` is then high for exactly one cycle. A request made while `busy` is high is ignored.
- R11: `tap_state` follows TMS on every TCK rising edge using the standard TAP transitions. When idle and not starting, `state_wr` loads it from `state_wdata`. Codes: 0 reset, 1 idle, 2..8 select/capture/shift/exit1/pause/exit2/update DR, 9..15 the same for IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle transfer request |
| bit_count | input | CNT_W | Number of bits N to shift |
| msb_first | input | 1 | Shift order: high = highest used position first |
| no_end | input | 1 | Stay in the shift state after the last bit |
| no_idle | input | 1 | Stop in the update state |
| data_in | input | 2**CNT_W | Bits to shift out |
| state_wr | input | 1 | Load the recorded TAP state |
| state_wdata | input | 4 | TAP state code to load |
| tdo | input | 1 | Test data from the TAP |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the TAP |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle refusal pulse |
| data_out | output | 2**CNT_W | Captured TDO bits |
| tap_state | output | 4 | Recorded TAP state code |

## Verification
The request is applied on one clock edge and accepted on the next, so `busy` is first seen high half a period after acceptance. `busy` then stays high for TCK_DIV x P cycles, and `done`, `data_out` and `tap_state` are read at the first falling clock edge where `done` is high. A refusal is checked at the very next falling edge: `err` must be high there, and a count of TCK rises taken over the following cycles must remain zero. A model of the target on the test clock records TDI and TMS at each rising edge and presents the next response bit after each falling edge. The bench compares the recorded sequences, the pulse count and the returned buffer against values it computes from the requested count, order and flags.

// File: rtl/jtseq_pkg.sv
package jtseq_pkg;

   typedef enum logic [3:0] {
      TS_RESET   = 4'd0,
      TS_IDLE    = 4'd1,
      TS_SEL_DR  = 4'd2,
      TS_CAP_DR  = 4'd3,
      TS_SH_DR   = 4'd4,
      TS_EX1_DR  = 4'd5,
      TS_PAU_DR  = 4'd6,
      TS_EX2_DR  = 4'd7,
      TS_UPD_DR  = 4'd8,
      TS_SEL_IR  = 4'd9,
      TS_CAP_IR  = 4'd10,
      TS_SH_IR   = 4'd11,
      TS_EX1_IR  = 4'd12,
      TS_PAU_IR  = 4'd13,
      TS_EX2_IR  = 4'd14,
      TS_UPD_IR  = 4'd15
   } tap_st_e;

   // Standard TAP controller transition on one TCK rising edge
   function automatic tap_st_e tap_step(tap_st_e s, logic m);
      tap_st_e n;
      case (s)
         TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
         TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: n = m ? TS_EX1_DR : TS_SH_DR;
         TS_SH_DR:  n = m ? TS_EX1_DR : TS_SH_DR;
         TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: n = m ? TS_UPD_DR : TS_SH_DR;
         TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: n = m ? TS_EX1_IR : TS_SH_IR;
         TS_SH_IR:  n = m ? TS_EX1_IR : TS_SH_IR;
         TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: n = m ? TS_UPD_IR : TS_SH_IR;
         default:   n = m ? TS_SEL_DR : TS_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jtseq_tick.sv
module jtseq_tick #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         logic [PW-1:0] ph;
         assign tick = run && (ph == PW'(HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ph <= '0;
            else if (!run)  ph <= '0;
            else if (tick)  ph <= '0;
            else            ph <= ph + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/jtseq_pos.sv
module jtseq_pos #(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W:0]   idx,
   input  logic [CNT_W-1:0] cnt,
   input  logic             msb,
   output logic [CNT_W-1:0] pos
);
   logic [CNT_W-1:0] up_pos;
   logic [CNT_W-1:0] dn_pos;

   assign up_pos = idx[CNT_W-1:0];
   assign dn_pos = cnt - 1'b1 - idx[CNT_W-1:0];
   assign pos    = msb ? dn_pos : up_pos;
endmodule

// File: rtl/jtseq_tap_track.sv
module jtseq_tap_track
   import jtseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [3:0] wdata,
   input  logic       adv,
   input  logic       tms_now,
   output tap_st_e    state
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= TS_RESET;
      else if (wr)   state <= tap_st_e'(wdata);
      else if (adv)  state <= tap_step(state, tms_now);
   end
endmodule

// File: rtl/jtag_shift_seq.sv
module jtag_shift_seq
   import jtseq_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int TCK_DIV = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [CNT_W-1:0]      bit_count,
   input  logic                  msb_first,
   input  logic                  no_end,
   input  logic                  no_idle,
   input  logic [2**CNT_W-1:0]   data_in,
   input  logic                  state_wr,
   input  logic [3:0]            state_wdata,
   input  logic                  tdo,
   output logic                  tck,
   output logic                  tms,
   output logic                  tdi,
   output logic                  busy,
   output logic                  done,
   output logic                  err,
   output logic [2**CNT_W-1:0]   data_out,
   output logic [3:0]            tap_state
);
   localparam int BUF_W = 2**CNT_W;
   localparam int HALF  = TCK_DIV / 2;

   initial begin
      assert (TCK_DIV >= 2 && (TCK_DIV % 2) == 0)
         else $error("TCK_DIV must be even and at least 2");
      assert (CNT_W >= 2 && CNT_W <= 12)
         else $error("CNT_W out of supported range");
   end

   tap_st_e          st;
   logic             tick;
   logic             accept;
   logic             in_shift;
   logic [CNT_W:0]   idx;
   logic [CNT_W:0]   idx_nxt;
   logic [CNT_W:0]   last_idx;
   logic [CNT_W-1:0] n_q;
   logic             msb_q, ne_q, ni_q;
   logic [BUF_W-1:0] buf_q;
   logic [CNT_W-1:0] cur_pos, nxt_pos;
   logic [CNT_W-1:0] first_pos;
   logic             nxt_tdi, nxt_tms;
   logic [CNT_W:0]   n_ext;
   logic             cur_data;

   assign in_shift  = (st == TS_SH_DR) || (st == TS_SH_IR);
   assign accept    = start && !busy && in_shift && (bit_count != '0);
   assign n_ext     = {1'b0, n_q};
   assign idx_nxt   = idx + 1'b1;
   assign cur_data  = idx < n_ext;
   assign first_pos = msb_first ? (bit_count - 1'b1) : '0;

   // Index of the final pulse: data bits, then exit and idle pulses
   always_comb begin
      if (ne_q)       last_idx = n_ext - 1'b1;
      else if (ni_q)  last_idx = n_ext;
      else            last_idx = n_ext + 1'b1;
   end

   jtseq_tick #(.HALF(HALF)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .tick (tick)
   );

   jtseq_pos #(.CNT_W(CNT_W)) u_pos_cur (
      .idx(idx), .cnt(n_q), .msb(msb_q), .pos(cur_pos)
   );

   jtseq_pos #(.CNT_W(CNT_W)) u_pos_nxt (
      .idx(idx_nxt), .cnt(n_q), .msb(msb_q), .pos(nxt_pos)
   );

   jtseq_tap_track u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (state_wr && !busy && !start),
      .wdata  (state_wdata),
      .adv    (busy && tick && !tck),
      .tms_now(tms),
      .state  (st)
   );

   assign tap_state = st;

   // Drive values for the pulse that follows the current one
   always_comb begin
      if (idx_nxt < n_ext) begin
         nxt_tdi = buf_q[nxt_pos];
         nxt_tms = (idx_nxt == n_ext - 1'b1) && !ne_q;
      end else begin
         nxt_tdi = 1'b0;
         nxt_tms = (idx_nxt == n_ext);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         tck      <= 1'b0;
         tms      <= 1'b0;
         tdi      <= 1'b0;
         idx      <= '0;
         n_q      <= '0;
         msb_q    <= 1'b0;
         ne_q     <= 1'b0;
         ni_q     <= 1'b0;
         buf_q    <= '0;
         data_out <= '0;
      end else begin
         done <= 1'b0;
         err  <= start && !busy && !accept;
         if (accept) begin
            busy     <= 1'b1;
            tck      <= 1'b0;
            idx      <= '0;
            n_q      <= bit_count;
            msb_q    <= msb_first;
            ne_q     <= no_end;
            ni_q     <= no_idle;
            buf_q    <= data_in;
            data_out <= '0;
            tdi      <= data_in[first_pos];
            tms      <= (bit_count == CNT_W'(1)) && !no_end;
         end else if (busy && tick) begin
            if (!tck) begin
               tck <= 1'b1;
            end else begin
               tck <= 1'b0;
               if (cur_data) data_out[cur_pos] <= tdo;
               if (idx == last_idx) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  tms  <= 1'b0;
                  tdi  <= 1'b0;
               end else begin
                  idx <= idx_nxt;
                  tdi <= nxt_tdi;
                  tms <= nxt_tms;
               end
            end
         end
      end
   end
endmodule

// File: rtl/jtseq_chk.sv
module jtseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       tck,
   input logic       tms,
   input logic       tdi,
   input logic       busy,
   input logic       done,
   input logic       err,
   input logic [3:0] tap_state
);
   // R2
   idle_tck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tck);

   // R9
   pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tck |-> ($stable(tdi) && $stable(tms)));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R1
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && tap_state != 4'd4 && tap_state != 4'd11) |=> (err && !busy));

   // R10
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);

   // R11
   track_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$rose(tck)) |-> $stable(tap_state));
endmodule

bind jtag_shift_seq jtseq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .tck      (tck),
   .tms      (tms),
   .tdi      (tdi),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .tap_state(tap_state)
);

// File: tb/jtag_shift_seq_tb.sv
module jtag_shift_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int CW         = 8;
   localparam int BW         = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] bit_count = '0;
   logic          msb_first = 1'b0, no_end = 1'b0, no_idle = 1'b0;
   logic [BW-1:0] data_in = '0;
   logic          state_wr = 1'b0;
   logic [3:0]    state_wdata = '0;
   logic          tdo = 1'b0;
   logic          tck, tms, tdi, busy, done, err;
   logic [BW-1:0] data_out;
   logic [3:0]    tap_state;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int nrise  = 0;
   logic [BW+3:0] rec_tdi, rec_tms;
   logic [BW-1:0] resp = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jtag_shift_seq #(.CNT_W(CW), .TCK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .bit_count(bit_count),
      .msb_first(msb_first), .no_end(no_end), .no_idle(no_idle),
      .data_in(data_in), .state_wr(state_wr), .state_wdata(state_wdata),
      .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done),
      .err(err), .data_out(data_out), .tap_state(tap_state)
   );

   // Target model: record on rising TCK, present next response after falling TCK
   always @(posedge tck) begin
      if (nrise < BW + 4) begin
         rec_tdi[nrise] = tdi;
         rec_tms[nrise] = tms;
      end
      nrise = nrise + 1;
   end
   always @(negedge tck) tdo = (nrise < BW) ? resp[nrise] : 1'b0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [BW-1:0] act, input logic [BW-1:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] rnd256();
      logic [BW-1:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic load_state(input logic [3:0] s);
      @(negedge clk);
      state_wr = 1'b1; state_wdata = s;
      @(negedge clk);
      state_wr = 1'b0;
   endtask

   // Full transfer with expected values built from the requirements
   task automatic xfer(input int n, input bit msb, input bit ne, input bit ni,
                       input logic [BW-1:0] d, input logic [BW-1:0] r,
                       input logic [3:0] st0, input bit do_load);
      int p, bcyc, guard, step;
      logic [BW+3:0] e_tdi, e_tms;
      logic [BW-1:0] e_out;
      logic [3:0] e_st;
      bit ok_tdi, ok_tms;
      if (do_load) load_state(st0);
      p = n + (ne ? 0 : (ni ? 1 : 2));
      e_tdi = '0; e_tms = '0; e_out = '0;
      for (int k = 0; k < n; k++) begin
         step = msb ? (n - 1 - k) : k;      // R3 / R4 position for step k
         e_tdi[k] = d[step];
         e_out[step] = r[k];                 // R5
      end
      if (!ne) begin
         e_tms[n-1] = 1'b1;                  // R6
         e_tms[n]   = 1'b1;                  // R7 exit pulse
      end
      if (ne)        e_st = st0;             // R8
      else if (ni)   e_st = (st0 == 4'd4) ? 4'd8 : 4'd15;
      else           e_st = 4'd1;
      @(negedge clk);
      nrise = 0; resp = r; tdo = r[0];
      rec_tdi = '0; rec_tms = '0;
      bit_count = CW'(n); msb_first = msb; no_end = ne; no_idle = ni;
      data_in = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      bcyc = 0; guard = 0;
      while (!done && guard < 5000) begin
         if (busy) bcyc++;
         guard++;
         @(negedge clk);
      end
      chk(done, "R10", "done seen", BW'(done), BW'(1));
      chk(bcyc == DIV * p, "R10", "busy cycles", BW'(bcyc), BW'(DIV * p));
      chk(nrise == p, "R2", "tck pulses", BW'(nrise), BW'(p));
      ok_tdi = 1'b1; ok_tms = 1'b1;
      for (int k = 0; k < p; k++) begin
         if (rec_tdi[k] !== e_tdi[k]) ok_tdi = 1'b0;
         if (rec_tms[k] !== e_tms[k]) ok_tms = 1'b0;
      end
      chk(ok_tdi, msb ? "R4" : "R3", "tdi sequence", rec_tdi[BW-1:0], e_tdi[BW-1:0]);
      chk(ok_tms, ne ? "R8" : "R6", "tms sequence", rec_tms[BW-1:0], e_tms[BW-1:0]);
      chk(data_out === e_out, "R5", "data_out", data_out, e_out);
      chk(tap_state === e_st, ne ? "R8" : "R7", "end state", BW'(tap_state), BW'(e_st));
      @(negedge clk);
      chk(!done, "R10", "done one cycle", BW'(done), BW'(0));
   endtask

   task automatic refuse(input int n, input logic [3:0] st0);
      load_state(st0);
      @(negedge clk);
      nrise = 0;
      bit_count = CW'(n); data_in = rnd256(); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err === 1'b1 && busy === 1'b0, "R1", "err pulse", BW'({err, busy}), BW'(2'b10));
      repeat (10) @(negedge clk);
      chk(nrise == 0 && !busy && !err, "R1", "no clocks", BW'(nrise), BW'(0));
      chk(tap_state === st0, "R11", "state kept", BW'(tap_state), BW'(st0));
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(tck === 1'b0 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
          "R2", "reset outputs", BW'({tck, busy, done, err}), BW'(0));
      chk(tap_state === 4'd0, "R11", "reset state", BW'(tap_state), BW'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R1 refusals: idle state, zero count
      refuse(8, 4'd1);
      refuse(0, 4'd4);

      // Directed corner cases
      xfer(1,   1'b0, 1'b0, 1'b0, rnd256(), rnd256(), 4'd4, 1'b1);
      xfer(1,   1'b1, 1'b0, 1'b1, rnd256(), rnd256(), 4'd11, 1'b1);
      xfer(255, 1'b1, 1'b0, 1'b0, rnd256(), rnd256(), 4'd11, 1'b1);
      xfer(255, 1'b0, 1'b0, 1'b1, {BW{1'b1}}, {BW{1'b1}}, 4'd4, 1'b1);
      xfer(13,  1'b1, 1'b0, 1'b0, 256'h1ABC, 256'h0F0F, 4'd4, 1'b1);
      // R8 continuation: stays in shift, second transfer needs no load
      xfer(20,  1'b0, 1'b1, 1'b0, rnd256(), rnd256(), 4'd4, 1'b1);
      xfer(9,   1'b1, 1'b1, 1'b1, rnd256(), rnd256(), 4'd4, 1'b0);
      xfer(9,   1'b0, 1'b0, 1'b0, rnd256(), rnd256(), 4'd4, 1'b0);
      // R11 tracking: after returning to idle, a new request is refused
      @(negedge clk);
      start = 1'b1; bit_count = 8'd4;
      @(negedge clk);
      start = 1'b0;
      chk(err === 1'b1, "R11", "refused after idle", BW'(err), BW'(1));

      // Constrained random transfers
      for (int t = 0; t < 24; t++) begin
         int n;
         n = 1 + ($urandom % 255);
         xfer(n, 1'($urandom), 1'($urandom), 1'($urandom), rnd256(), rnd256(),
              ($urandom % 2) ? 4'd4 : 4'd11, 1'b1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule